// File: doc/BRIEF.md
# Power-Down Clock Output Sequencer

This block sits between the synthesizer of a multi-output clock generator and its output pins. It stops every output cleanly when a power-down request arrives, and brings them back cleanly on wake. The request pin is asynchronous and active high. It is first resynchronized, then qualified against the reference differential clock. Every single-ended clock is then frozen low and every differential group is parked without a runt pulse. Only after all of that does the block ask for the oscillator and PLL to be stopped.

On wake, the stop request is withdrawn and a reference-tick timer starts. After a programmable delay, any differential true output that was parked tristated is driven high again. Once the PLL reports lock, each output resumes at a low phase of its own clock, so the first pulse is full width. A sticky error flag is raised if the outputs are not all running again within a programmable wake window. The block runs on a fast sampling clock whose period is the reference tick. The clock phases it gates arrive as level inputs and leave through one register stage.

Top module: `clkPwrDownSeq`

## Requirements
- R1: The request pin passes through two synchronizer flops. The block leaves the running state (`allRunning` drops) only after the synchronized request has been high at two consecutive rising edges of the reference complement, which is a high-to-low change of `diffIn[0]`. A lower request clears that count.
- R2: While enabled, `seOut[i]` equals `seIn[i]` one cycle later. On park, the output is frozen at the first cycle in which `seIn[i]` is low, and it stays low without ever producing a shortened high pulse.
- R3: While enabled, `diffT[g]` and `diffC[g]` follow `diffIn[g]` and its inverse one cycle later. A group parks at the first cycle in which its complement has fallen (`diffIn[g]` high). While parked, `diffT[g]`=1 and `diffC[g]`=0.
- R4: A parked group with `diffMode[g]`=0 has `diffTOe[g]`=1 and `diffCOe[g]`=0.
- R5: A parked group with `diffMode[g]`=1 has both `diffTOe[g]` and `diffCOe[g]` at 0 until the re-drive of R8.
- R6: Once FORCE_EDGES reference complement edges have passed in the parking phase, every differential group is parked on the next cycle, even if its own clock has stopped.
- R7: `oscPllStop` rises only after every output is parked. It stays high until the synchronized request is low.
- R8: After `oscPllStop` falls, every parked tristated true output is driven high (`diffTOe[g]`=1) once REDRIVE_TICKS ticks have passed.
- R9: While `pllLock` is high during wake, each output is re-enabled at a cycle in which its input is low. When all outputs are enabled, `allRunning` returns to 1.
- R10: `wakeErr` is set if WAKE_TIMEOUT ticks of wake pass without all outputs enabled. It is held through the return to running and cleared when the next power-down is qualified.
- R11: After reset, the block is running with all outputs enabled: `allRunning`=1, `oscPllStop`=0, `wakeErr`=0, and all output enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, one reference tick per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| pdReq | input | 1 | Asynchronous power-down request, active high |
| seIn | input | NUM_SE | Single-ended clock phases from the synthesizer |
| diffIn | input | NUM_DIFF | True phase of each differential group; bit 0 is the reference (CPU) group |
| diffMode | input | NUM_DIFF | Park style per group: 0 true high and complement off, 1 both off |
| pllLock | input | 1 | PLL locked indication |
| seOut | output | NUM_SE | Gated single-ended clocks |
| diffT | output | NUM_DIFF | Differential true outputs |
| diffC | output | NUM_DIFF | Differential complement outputs |
| diffTOe | output | NUM_DIFF | Output enables of the true outputs |
| diffCOe | output | NUM_DIFF | Output enables of the complement outputs |
| oscPllStop | output | 1 | Request to stop oscillator and PLL; also the fully stopped status |
| allRunning | output | 1 | Fully running status |
| wakeErr | output | 1 | Sticky wake timeout flag |

## Verification
The bench builds the block with REDRIVE_TICKS=20, WAKE_TIMEOUT=60 and FORCE_EDGES=4, using two single-ended outputs and three differential groups. These short windows let a single run reach both the re-drive of tristated outputs and a wake that overruns its window, in place of the hundreds of thousands of ticks the defaults imply. Group 2 is frozen low in one power-down, so the forced park after four reference edges is reached. The modes are changed between power-downs, so both park styles are seen on every group.

// File: rtl/pdSeqPkg.sv
package pdSeqPkg;
  typedef enum logic [1:0] {ST_RUN, ST_PARK, ST_OFF, ST_WAKE} pdState_e;

  typedef struct packed {
    logic parkReq;
    logic forcePark;
    logic wakeReq;
    logic redrive;
  } seqStrobe_t;
endpackage

// File: rtl/pdSeqCtrl.sv
module pdSeqCtrl
  import pdSeqPkg::*;
#(
  parameter int REDRIVE_TICKS = 60000,
  parameter int WAKE_TIMEOUT  = 360000,
  parameter int FORCE_EDGES   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pdReq,
  input  logic       cpuTrue,
  input  logic       pllLock,
  input  logic       allParked,
  input  logic       allEnabled,
  output seqStrobe_t strobe,
  output logic       oscPllStop,
  output logic       allRunning,
  output logic       wakeErr
);
  localparam int TICK_W = $clog2(WAKE_TIMEOUT + 1);
  localparam int EDGE_W = $clog2(FORCE_EDGES + 1);
  localparam logic [TICK_W-1:0] TICK_MAX = TICK_W'(WAKE_TIMEOUT);
  localparam logic [TICK_W-1:0] TICK_RDR = TICK_W'(REDRIVE_TICKS);
  localparam logic [EDGE_W-1:0] EDGE_MAX = EDGE_W'(FORCE_EDGES);

  logic pdMeta, pdSync, cpuPrev, cpuRise, pdQual;
  logic [1:0] qualCnt;
  logic [EDGE_W-1:0] parkEdges;
  logic [TICK_W-1:0] tick;
  pdState_e state, stateNext;

  // complement rises when the true phase falls
  assign cpuRise = cpuPrev & ~cpuTrue;
  assign pdQual  = (qualCnt == 2'd2);

  always_comb begin
    stateNext = state;
    case (state)
      ST_RUN:  if (pdQual)     stateNext = ST_PARK;
      ST_PARK: if (allParked)  stateNext = ST_OFF;
      ST_OFF:  if (!pdSync)    stateNext = ST_WAKE;
      ST_WAKE: if (allEnabled) stateNext = ST_RUN;
      default: stateNext = ST_RUN;
    endcase
  end

  assign strobe.parkReq   = (state == ST_PARK);
  assign strobe.forcePark = (state == ST_PARK) && (parkEdges >= EDGE_MAX);
  assign strobe.wakeReq   = (state == ST_WAKE) && pllLock;
  assign strobe.redrive   = (state == ST_WAKE) && (tick >= TICK_RDR);
  assign oscPllStop       = (state == ST_OFF);
  assign allRunning       = (state == ST_RUN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pdMeta    <= 1'b0;
      pdSync    <= 1'b0;
      cpuPrev   <= 1'b0;
      qualCnt   <= '0;
      parkEdges <= '0;
      tick      <= '0;
      wakeErr   <= 1'b0;
      state     <= ST_RUN;
    end else begin
      pdMeta  <= pdReq;
      pdSync  <= pdMeta;
      cpuPrev <= cpuTrue;
      state   <= stateNext;
      if (state != ST_RUN || !pdSync) qualCnt <= '0;
      else if (cpuRise && !pdQual)    qualCnt <= qualCnt + 2'd1;
      if (state != ST_PARK)                    parkEdges <= '0;
      else if (cpuRise && parkEdges < EDGE_MAX) parkEdges <= parkEdges + 1'b1;
      if (state != ST_WAKE)     tick <= '0;
      else if (tick < TICK_MAX) tick <= tick + 1'b1;
      if (state == ST_RUN && pdQual) wakeErr <= 1'b0;
      else if (state == ST_WAKE && tick == TICK_MAX && !allEnabled) wakeErr <= 1'b1;
    end
  end

  AST_QUAL_TWO_EDGES: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PARK && $past(state) == ST_RUN) |-> $past(pdSync, 2)); // R1
  AST_STOP_AFTER_PARK: assert property (@(posedge clk) disable iff (!rstN)
    oscPllStop |-> allParked); // R7
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (oscPllStop && pdSync) |=> oscPllStop); // R7
  AST_ERR_IN_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeErr) |-> $past(state) == ST_WAKE); // R10
endmodule

// File: rtl/pdSeqPath.sv
module pdSeqPath
  import pdSeqPkg::*;
#(
  parameter int NUM_SE   = 4,
  parameter int NUM_DIFF = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobe,
  input  logic [NUM_SE-1:0]   seIn,
  input  logic [NUM_DIFF-1:0] diffIn,
  input  logic [NUM_DIFF-1:0] diffMode,
  output logic [NUM_SE-1:0]   seOut,
  output logic [NUM_DIFF-1:0] diffT,
  output logic [NUM_DIFF-1:0] diffC,
  output logic [NUM_DIFF-1:0] diffTOe,
  output logic [NUM_DIFF-1:0] diffCOe,
  output logic                allParked,
  output logic                allEnabled
);
  logic [NUM_SE-1:0]   seEn, seEnNext;
  logic [NUM_DIFF-1:0] diffEn, diffEnNext, redrv, redrvNext;

  assign allParked  = ~|seEn & ~|diffEn;
  assign allEnabled = &seEn & &diffEn;

  for (genvar i = 0; i < NUM_SE; i++) begin : gSe
    // freeze and release only while the input is low
    always_comb begin
      seEnNext[i] = seEn[i];
      if (strobe.parkReq)      seEnNext[i] = seEn[i] & seIn[i];
      else if (strobe.wakeReq) seEnNext[i] = seEn[i] | ~seIn[i];
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        seEn[i]  <= 1'b1;
        seOut[i] <= 1'b0;
      end else begin
        seEn[i]  <= seEnNext[i];
        seOut[i] <= seEnNext[i] & seIn[i];
      end
    end
    AST_SE_NO_RUNT: assert property (@(posedge clk) disable iff (!rstN)
      !seEn[i] |-> !seOut[i]); // R2
  end

  for (genvar g = 0; g < NUM_DIFF; g++) begin : gDiff
    // park with true high, resume with true low
    always_comb begin
      diffEnNext[g] = diffEn[g];
      if (strobe.forcePark)    diffEnNext[g] = 1'b0;
      else if (strobe.parkReq) diffEnNext[g] = diffEn[g] & ~diffIn[g];
      else if (strobe.wakeReq) diffEnNext[g] = diffEn[g] | ~diffIn[g];
      redrvNext[g] = strobe.parkReq ? 1'b0 : (redrv[g] | strobe.redrive);
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        diffEn[g]  <= 1'b1;
        redrv[g]   <= 1'b0;
        diffT[g]   <= 1'b0;
        diffC[g]   <= 1'b1;
        diffTOe[g] <= 1'b1;
        diffCOe[g] <= 1'b1;
      end else begin
        diffEn[g]  <= diffEnNext[g];
        redrv[g]   <= redrvNext[g];
        diffT[g]   <= diffEnNext[g] ? diffIn[g] : 1'b1;
        diffC[g]   <= diffEnNext[g] & ~diffIn[g];
        diffTOe[g] <= diffEnNext[g] | ~diffMode[g] | redrvNext[g];
        diffCOe[g] <= diffEnNext[g];
      end
    end
    AST_PARK_TRUE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
      !diffEn[g] |-> (diffT[g] && !diffC[g] && !diffCOe[g])); // R4
    AST_MODE1_TRISTATE: assert property (@(posedge clk) disable iff (!rstN)
      (!diffEn[g] && $past(diffMode[g]) && !redrv[g]) |-> !diffTOe[g]); // R5
  end

  AST_FORCE_DEADLINE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.forcePark |=> (diffEn == '0)); // R6
endmodule

// File: rtl/clkPwrDownSeq.sv
module clkPwrDownSeq
  import pdSeqPkg::*;
#(
  parameter int NUM_SE        = 4,
  parameter int NUM_DIFF      = 3,
  parameter int REDRIVE_TICKS = 60000,
  parameter int WAKE_TIMEOUT  = 360000,
  parameter int FORCE_EDGES   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pdReq,
  input  logic [NUM_SE-1:0]   seIn,
  input  logic [NUM_DIFF-1:0] diffIn,
  input  logic [NUM_DIFF-1:0] diffMode,
  input  logic                pllLock,
  output logic [NUM_SE-1:0]   seOut,
  output logic [NUM_DIFF-1:0] diffT,
  output logic [NUM_DIFF-1:0] diffC,
  output logic [NUM_DIFF-1:0] diffTOe,
  output logic [NUM_DIFF-1:0] diffCOe,
  output logic                oscPllStop,
  output logic                allRunning,
  output logic                wakeErr
);
  seqStrobe_t strobe;
  logic allParked, allEnabled;

  pdSeqCtrl #(
    .REDRIVE_TICKS(REDRIVE_TICKS), .WAKE_TIMEOUT(WAKE_TIMEOUT), .FORCE_EDGES(FORCE_EDGES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .pdReq(pdReq), .cpuTrue(diffIn[0]), .pllLock(pllLock),
    .allParked(allParked), .allEnabled(allEnabled), .strobe(strobe),
    .oscPllStop(oscPllStop), .allRunning(allRunning), .wakeErr(wakeErr)
  );

  pdSeqPath #(.NUM_SE(NUM_SE), .NUM_DIFF(NUM_DIFF)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .seIn(seIn), .diffIn(diffIn),
    .diffMode(diffMode), .seOut(seOut), .diffT(diffT), .diffC(diffC),
    .diffTOe(diffTOe), .diffCOe(diffCOe), .allParked(allParked), .allEnabled(allEnabled)
  );
endmodule

// File: tb/clkPwrDownSeq_test.sv
`timescale 1ns/1ps
module clkPwrDownSeq_test;
  localparam int NSE = 2, ND = 3, RDR = 20, TMO = 60, FE = 4;

  logic clk = 1'b0, rstN = 1'b0, pdReq = 1'b0, pllLock = 1'b1;
  logic [NSE-1:0] seIn = '0;
  logic [ND-1:0] diffIn = '0, diffMode = '0;
  logic freeze2 = 1'b0;
  logic [NSE-1:0] seOut;
  logic [ND-1:0] diffT, diffC, diffTOe, diffCOe;
  logic oscPllStop, allRunning, wakeErr;
  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  clkPwrDownSeq #(.NUM_SE(NSE), .NUM_DIFF(ND), .REDRIVE_TICKS(RDR),
                  .WAKE_TIMEOUT(TMO), .FORCE_EDGES(FE)) uut (
    .clk(clk), .rstN(rstN), .pdReq(pdReq), .seIn(seIn), .diffIn(diffIn),
    .diffMode(diffMode), .pllLock(pllLock), .seOut(seOut), .diffT(diffT),
    .diffC(diffC), .diffTOe(diffTOe), .diffCOe(diffCOe), .oscPllStop(oscPllStop),
    .allRunning(allRunning), .wakeErr(wakeErr));

  // behavioural reference: phase names 0 run, 1 park, 2 off, 3 wake
  int ph, q, pe, tk;
  bit s1, s2, prev0, eErr;
  bit mSeEn[NSE], mSeO[NSE];
  bit mDEn[ND], mRd[ND], mT[ND], mC[ND], mTOe[ND], mCOe[ND];

  always @(posedge clk) begin
    if (!rstN) begin
      ph = 0; q = 0; pe = 0; tk = 0; s1 = 0; s2 = 0; prev0 = 0; eErr = 0;
      foreach (mSeEn[i]) begin mSeEn[i] = 1; mSeO[i] = 0; end
      foreach (mDEn[g]) begin
        mDEn[g] = 1; mRd[g] = 0; mT[g] = 0; mC[g] = 1; mTOe[g] = 1; mCOe[g] = 1;
      end
    end else begin
      bit rise, parked, enabled, park, force_, wake, rdS;
      int nph;
      rise = prev0 && !diffIn[0];
      parked = 1; enabled = 1;
      foreach (mSeEn[i]) begin parked &= !mSeEn[i]; enabled &= mSeEn[i]; end
      foreach (mDEn[g]) begin parked &= !mDEn[g]; enabled &= mDEn[g]; end
      park = (ph == 1); force_ = (ph == 1) && (pe >= FE);
      wake = (ph == 3) && pllLock; rdS = (ph == 3) && (tk >= RDR);
      foreach (mSeEn[i]) begin
        if (park) mSeEn[i] = mSeEn[i] && seIn[i];
        else if (wake && !seIn[i]) mSeEn[i] = 1;
        mSeO[i] = mSeEn[i] && seIn[i];
      end
      foreach (mDEn[g]) begin
        if (force_) mDEn[g] = 0;
        else if (park) mDEn[g] = mDEn[g] && !diffIn[g];
        else if (wake && !diffIn[g]) mDEn[g] = 1;
        mRd[g] = park ? 0 : (mRd[g] || rdS);
        mT[g] = mDEn[g] ? diffIn[g] : 1'b1;
        mC[g] = mDEn[g] && !diffIn[g];
        mTOe[g] = mDEn[g] || !diffMode[g] || mRd[g];
        mCOe[g] = mDEn[g];
      end
      nph = ph;
      if (ph == 0 && q == 2) nph = 1;
      if (ph == 1 && parked) nph = 2;
      if (ph == 2 && !s2) nph = 3;
      if (ph == 3 && enabled) nph = 0;
      if (ph == 0 && q == 2) eErr = 0;
      else if (ph == 3 && tk == TMO && !enabled) eErr = 1;
      if (ph != 0 || !s2) q = 0; else if (rise && q < 2) q++;
      if (ph != 1) pe = 0; else if (rise && pe < FE) pe++;
      if (ph != 3) tk = 0; else if (tk < TMO) tk++;
      ph = nph; s2 = s1; s1 = pdReq; prev0 = diffIn[0];
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (rstN) begin
    foreach (mSeO[i]) chk("R2 R9 seOut", int'(seOut[i]), int'(mSeO[i]));
    foreach (mT[g]) begin
      chk("R3 R6 R9 diffT", int'(diffT[g]), int'(mT[g]));
      chk("R3 R6 diffC", int'(diffC[g]), int'(mC[g]));
      chk("R4 R5 R8 diffTOe", int'(diffTOe[g]), int'(mTOe[g]));
      chk("R4 R5 diffCOe", int'(diffCOe[g]), int'(mCOe[g]));
    end
    chk("R7 oscPllStop", int'(oscPllStop), int'(ph == 2));
    chk("R1 R9 allRunning", int'(allRunning), int'(ph == 0));
    chk("R10 wakeErr", int'(wakeErr), int'(eErr));
  end

  // clock phase sources, changed just after each falling edge
  initial forever begin
    @(negedge clk); #1;
    cyc++;
    diffIn[0] = ((cyc / 4) % 2) != 0;
    diffIn[1] = ((cyc / 5) % 2) != 0;
    diffIn[2] = freeze2 ? 1'b0 : (((cyc / 3) % 2) != 0);
    seIn[0]   = ((cyc / 3) % 2) != 0;
    seIn[1]   = ((cyc / 7) % 2) != 0;
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    waitCyc(3); #1 rstN = 1'b1;
    @(negedge clk);
    chk("R11 reset running", int'(allRunning), 1);
    chk("R11 reset stop", int'(oscPllStop), 0);
    chk("R11 reset err", int'(wakeErr), 0);
    chk("R11 reset oe", int'({diffTOe, diffCOe}), 6'h3f);
    waitCyc(40);
    // short glitch on request: must not qualify
    #1 pdReq = 1'b1; waitCyc(2); #1 pdReq = 1'b0; waitCyc(20);
    chk("R1 glitch ignored", int'(allRunning), 1);
    // power-down one: group 1 tristated, group 2 stalled to force park
    diffMode = 3'b010; pdReq = 1'b1; freeze2 = 1'b1;
    waitCyc(80);
    chk("R7 stopped", int'(oscPllStop), 1);
    #1 pllLock = 1'b0; pdReq = 1'b0; freeze2 = 1'b0;
    waitCyc(35);
    chk("R8 redriven", int'(diffTOe[1]), 1);
    #1 pllLock = 1'b1; waitCyc(40);
    chk("R9 running again", int'(allRunning), 1);
    // power-down two: all tristated, lock held off past the window
    #1 diffMode = 3'b111; pdReq = 1'b1; waitCyc(80);
    #1 pllLock = 1'b0; pdReq = 1'b0; waitCyc(90);
    chk("R10 timeout flagged", int'(wakeErr), 1);
    #1 pllLock = 1'b1; waitCyc(40);
    chk("R10 flag held", int'(wakeErr), 1);
    // power-down three clears the flag
    #1 diffMode = 3'b001; pdReq = 1'b1; waitCyc(80);
    chk("R10 flag cleared", int'(wakeErr), 0);
    #1 pdReq = 1'b0; waitCyc(60);
    chk("R9 final running", int'(allRunning), 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5ns * 20000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule